// File: doc/BRIEF.md
# Mode-Banked Register File with Status Register

This block holds the general-purpose registers of a 32-bit core together with its 8-bit status register. It offers two combinational read ports and one clocked write port. Register 0 is hardwired to zero. Registers 1 to 27 form one set that every mode shares. Registers 28 to 31 are overlaid in three copies, so an interrupt or exception handler gets its own scratch registers without saving the interrupted code's registers.

The status register holds two things. Its low nibble holds the ALU condition flags. Its high nibble holds the mode bits, and those bits choose which overlay copy the read and write ports reach. Software writes the whole status byte. The ALU updates only the flag nibble. Decode, interrupt control and context save to memory are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every register copy and the status register to zero, and both take effect while reset is held.
- R2: Address 0 always reads as zero on both ports. A write to address 0 changes no register.
- R3: Registers 1 to 27 are a single set. A value written to one of them in any mode reads back in every other mode.
- R4: Overlay selection follows the status register. Bit 6 set selects the hardware-interrupt copy. Otherwise, bit 4 or bit 5 set selects the exception/software-interrupt copy. Otherwise the normal copy is used. The values 0x80, 0xB0 and 0xC0 select the normal, exception and hardware-interrupt copies.
- R5: A write to registers 28 to 31 changes only the copy selected at that clock edge. The other two copies keep their contents.
- R6: Both read ports are combinational and independent. A write becomes visible only after the clock edge that performs it. It is not forwarded to a read of the same address in the same cycle.
- R7: When a software status write and an ALU flag update occur in the same cycle, the status register takes the software value.
- R8: An ALU flag update alone loads flag_i into status bits 3:0 and leaves bits 7:4 unchanged. The flag bits are carry = bit 0, overflow = bit 1, zero = bit 2 and negative = bit 3.
- R9: With neither a status write nor a flag update, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 5 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| sr_we_i | input | 1 | Software status register write enable |
| sr_wdata_i | input | 8 | Software status register write value |
| flag_we_i | input | 1 | ALU flag update enable |
| flag_i | input | 4 | ALU flags {negative, zero, overflow, carry} |
| sr_o | output | 8 | Current status register |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits, the top four overlaid in three copies. This puts the boundary between the shared set and the overlay at address 28, so register 27 and register 28 sit on opposite sides of it. The three-way priority of the mode bits is reachable through the single-bit and mixed status values, and each overlay copy is written and then observed from the other modes. The same-cycle cases are driven directly: write-then-read on one address, and a software status write together with a flag update.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int SR_W     = 8;
  localparam int FLAG_W   = 4;
  localparam int SR_SWI   = 4;
  localparam int SR_EXC   = 5;
  localparam int SR_HWI   = 6;
  localparam int N_COPIES = 3;

  typedef enum logic [1:0] {
    COPY_NORM = 2'd0,
    COPY_EXC  = 2'd1,
    COPY_HWI  = 2'd2
  } copy_e;
endpackage

// File: rtl/rf_copy_sel.sv
module rf_copy_sel
  import banked_rf_pkg::*;
(
  input  logic [SR_W-1:0] sr_i,
  output copy_e           copy_o
);
  always_comb begin
    if (sr_i[SR_HWI])                        copy_o = COPY_HWI;
    else if (sr_i[SR_SWI] || sr_i[SR_EXC])   copy_o = COPY_EXC;
    else                                     copy_o = COPY_NORM;
  end
endmodule

// File: rtl/rf_status_reg.sv
module rf_status_reg
  import banked_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [SR_W-1:0]   sr_o
);
  logic [SR_W-1:0] sr_q;

  // software write wins over flag update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (sr_we_i)   sr_q <= sr_wdata_i;
    else if (flag_we_i) sr_q <= {sr_q[SR_W-1:FLAG_W], flag_i};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/rf_shared_regs.sv
module rf_shared_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LO     = 1,
  parameter int HI     = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [LO:HI];

  for (genvar g = LO; g <= HI; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))      mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = LO; i <= HI; i++) begin
      if (raddr_a_i == ADDR_W'(i)) rdata_a_o = mem_q[i];
      if (raddr_b_i == ADDR_W'(i)) rdata_b_o = mem_q[i];
    end
  end
endmodule

// File: rtl/rf_overlay_regs.sv
module rf_overlay_regs
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COUNT  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  copy_e                     copy_i,
  input  logic                      we_i,
  input  logic [$clog2(COUNT)-1:0]  widx_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [$clog2(COUNT)-1:0]  ridx_a_i,
  output logic [DATA_W-1:0]         rdata_a_o,
  input  logic [$clog2(COUNT)-1:0]  ridx_b_i,
  output logic [DATA_W-1:0]         rdata_b_o
);
  logic [DATA_W-1:0] mem_q [N_COPIES][COUNT];

  for (genvar c = 0; c < N_COPIES; c++) begin : g_copy
    for (genvar r = 0; r < COUNT; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[c][r] <= '0;
        else if (we_i && (copy_i == copy_e'(c)) && (int'(widx_i) == r))
          mem_q[c][r] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int c = 0; c < N_COPIES; c++) begin
      if (copy_i == copy_e'(c)) begin
        rdata_a_o = mem_q[c][ridx_a_i];
        rdata_b_o = mem_q[c][ridx_b_i];
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 32,
  parameter int NUM_BANKED = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0]           rd_a_data_o,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0]           rd_b_data_o,
  input  logic                        wr_en_i,
  input  logic [$clog2(NUM_REGS)-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        sr_we_i,
  input  logic [SR_W-1:0]             sr_wdata_i,
  input  logic                        flag_we_i,
  input  logic [FLAG_W-1:0]           flag_i,
  output logic [SR_W-1:0]             sr_o
);
  localparam int ADDR_W      = $clog2(NUM_REGS);
  localparam int IDX_W       = $clog2(NUM_BANKED);
  localparam int FIRST_OVL   = NUM_REGS - NUM_BANKED;
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_OVL);

  logic [SR_W-1:0]   sr_q;
  copy_e             copy;
  logic              w_ovl, w_shr;
  logic [DATA_W-1:0] shr_a, shr_b, ovl_a, ovl_b;
  logic [ADDR_W-1:0] w_off, a_off, b_off;

  rf_status_reg u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sr_we_i    (sr_we_i),
    .sr_wdata_i (sr_wdata_i),
    .flag_we_i  (flag_we_i),
    .flag_i     (flag_i),
    .sr_o       (sr_q)
  );

  rf_copy_sel u_sel (
    .sr_i   (sr_q),
    .copy_o (copy)
  );

  assign w_ovl = wr_en_i && (wr_addr_i >= FIRST_A);
  assign w_shr = wr_en_i && (wr_addr_i <  FIRST_A) && (wr_addr_i != '0);
  assign w_off = wr_addr_i   - FIRST_A;
  assign a_off = rd_a_addr_i - FIRST_A;
  assign b_off = rd_b_addr_i - FIRST_A;

  rf_shared_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LO     (1),
    .HI     (FIRST_OVL - 1)
  ) u_shared (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (w_shr),
    .waddr_i   (wr_addr_i),
    .wdata_i   (wr_data_i),
    .raddr_a_i (rd_a_addr_i),
    .rdata_a_o (shr_a),
    .raddr_b_i (rd_b_addr_i),
    .rdata_b_o (shr_b)
  );

  rf_overlay_regs #(
    .DATA_W (DATA_W),
    .COUNT  (NUM_BANKED)
  ) u_overlay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .copy_i    (copy),
    .we_i      (w_ovl),
    .widx_i    (w_off[IDX_W-1:0]),
    .wdata_i   (wr_data_i),
    .ridx_a_i  (a_off[IDX_W-1:0]),
    .rdata_a_o (ovl_a),
    .ridx_b_i  (b_off[IDX_W-1:0]),
    .rdata_b_o (ovl_b)
  );

  // address 0 falls into the shared range and returns zero there
  assign rd_a_data_o = (rd_a_addr_i >= FIRST_A) ? ovl_a : shr_a;
  assign rd_b_data_o = (rd_b_addr_i >= FIRST_A) ? ovl_b : shr_b;
  assign sr_o        = sr_q;
endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 32,
  parameter int NUM_BANKED = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [$clog2(NUM_REGS)-1:0] rd_a_addr_i,
  input logic [DATA_W-1:0]           rd_a_data_o,
  input logic [$clog2(NUM_REGS)-1:0] rd_b_addr_i,
  input logic [DATA_W-1:0]           rd_b_data_o,
  input logic                        wr_en_i,
  input logic [$clog2(NUM_REGS)-1:0] wr_addr_i,
  input logic [DATA_W-1:0]           wr_data_i,
  input logic                        sr_we_i,
  input logic [7:0]                  sr_wdata_i,
  input logic                        flag_we_i,
  input logic [3:0]                  flag_i,
  input logic [7:0]                  sr_o
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(NUM_REGS - NUM_BANKED);

  p_zero_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));

  p_zero_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0));

  p_shared_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i != '0) && (wr_addr_i < FIRST_A))
    |=> ((rd_a_addr_i != $past(wr_addr_i)) || (rd_a_data_o == $past(wr_data_i))));

  p_sw_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_i |=> (sr_o == $past(sr_wdata_i)));

  p_flag_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !sr_we_i)
    |=> ((sr_o[7:4] == $past(sr_o[7:4])) && (sr_o[3:0] == $past(flag_i))));

  p_sr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !sr_we_i) |=> $stable(sr_o));
endmodule

bind banked_regfile banked_regfile_checker #(
  .DATA_W     (DATA_W),
  .NUM_REGS   (NUM_REGS),
  .NUM_BANKED (NUM_BANKED)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_b_data_o (rd_b_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .sr_we_i     (sr_we_i),
  .sr_wdata_i  (sr_wdata_i),
  .flag_we_i   (flag_we_i),
  .flag_i      (flag_i),
  .sr_o        (sr_o)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, sr_we_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0]  sr_wdata_i = '0, sr_o;
  logic [3:0]  flag_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  banked_regfile uut (.*);

  typedef struct packed {
    logic [7:0]  sr;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 5'd28, 32'h1111_1111, 5'd28, 32'h1111_1111},  // R4 normal copy
    '{8'hB0, 5'd28, 32'h2222_2222, 5'd28, 32'h2222_2222},  // R4 exc copy
    '{8'hC0, 5'd28, 32'h3333_3333, 5'd28, 32'h3333_3333},  // R4 hwi copy
    '{8'h80, 5'd0,  32'hDEAD_BEEF, 5'd28, 32'h1111_1111},  // R5 normal kept
    '{8'h10, 5'd5,  32'h0000_0055, 5'd28, 32'h2222_2222},  // R4 bit4 only
    '{8'h20, 5'd31, 32'hA5A5_A5A5, 5'd5,  32'h0000_0055},  // R3 shared
    '{8'h50, 5'd1,  32'h0000_0001, 5'd28, 32'h3333_3333},  // R4 bit6 wins
    '{8'h60, 5'd2,  32'h0000_0002, 5'd31, 32'h0000_0000},  // R5 hwi r31 empty
    '{8'hB0, 5'd3,  32'h0000_0003, 5'd31, 32'hA5A5_A5A5},  // R5 exc r31
    '{8'h00, 5'd4,  32'h0000_0004, 5'd31, 32'h0000_0000},  // R5 normal r31 empty
    '{8'h80, 5'd6,  32'h0000_0006, 5'd0,  32'h0000_0000},  // R2 zero read
    '{8'hC0, 5'd27, 32'h0000_0027, 5'd27, 32'h0000_0027}   // R3 last shared
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rd_a_addr_i = 5'd28;
    rd_b_addr_i = 5'd5;
    #1;
    check("R1 sr in reset", {24'h0, sr_o}, 32'h0);
    check("R1 r28 in reset", rd_a_data_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 r5 after reset", rd_b_data_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      sr_we_i = 1'b1; sr_wdata_i = VECS[i].sr;
      @(negedge clk_i);
      sr_we_i = 1'b0;
      wr_en_i = 1'b1; wr_addr_i = VECS[i].wa; wr_data_i = VECS[i].wd;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      rd_a_addr_i = VECS[i].ra; rd_b_addr_i = VECS[i].ra;
      #1;
      check($sformatf("vector %0d port A (R3/R4/R5)", i), rd_a_data_o, VECS[i].exp);
      check($sformatf("vector %0d port B (R6)", i), rd_b_data_o, VECS[i].exp);
    end

    // R6: same-cycle write is not forwarded
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd9; wr_data_i = 32'h0000_0099;
    rd_a_addr_i = 5'd9; rd_b_addr_i = 5'd27;
    #1;
    check("R6 no forward", rd_a_data_o, 32'h0);
    check("R6 port B independent", rd_b_data_o, 32'h0000_0027);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check("R6 visible after edge", rd_a_data_o, 32'h0000_0099);

    // R2: write to address 0 ignored
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd0; wr_data_i = 32'hFFFF_FFFF;
    rd_a_addr_i = 5'd0; rd_b_addr_i = 5'd0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check("R2 r0 port A", rd_a_data_o, 32'h0);
    check("R2 r0 port B", rd_b_data_o, 32'h0);

    // R7: software write beats flag update
    @(negedge clk_i);
    sr_we_i = 1'b1; sr_wdata_i = 8'hB0; flag_we_i = 1'b1; flag_i = 4'hF;
    @(negedge clk_i);
    sr_we_i = 1'b0; flag_we_i = 1'b0;
    #1;
    check("R7 sw priority", {24'h0, sr_o}, 32'h0000_00B0);

    // R8: flags only touch low nibble, copy unchanged
    @(negedge clk_i);
    flag_we_i = 1'b1; flag_i = 4'b1010;
    rd_a_addr_i = 5'd28;
    @(negedge clk_i);
    flag_we_i = 1'b0; flag_i = 4'h0;
    #1;
    check("R8 flag update", {24'h0, sr_o}, 32'h0000_00BA);
    check("R8 mode copy kept", rd_a_data_o, 32'h2222_2222);

    // R9: status holds when idle
    repeat (2) @(negedge clk_i);
    #1;
    check("R9 sr hold", {24'h0, sr_o}, 32'h0000_00BA);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    rd_b_addr_i = 5'd9;
    #1;
    check("R1 async sr", {24'h0, sr_o}, 32'h0);
    check("R1 async r28", rd_a_data_o, 32'h0);
    check("R1 async r9", rd_b_data_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule